// File: doc/BRIEF.md
# Effective Address Unit

This unit sits between instruction decode and operand fetch. It receives the mode code, a register selector and the address field of an instruction that has already been decoded. From these it produces one of three results: an immediate operand, a register operand, or the effective address that the later memory access will use. When the mode produces nothing, the result is empty.

Most modes need only the register file's combinational read port and the address of the current instruction, so they finish in one cycle. The memory-indirect mode makes one extra read, at the address given in the field, and waits for the memory to return the pointer. The post-increment and post-decrement modes return the register's old value as the address. They write the stepped value back to the register file in the same cycle as the done strobe.

All address arithmetic wraps modulo 2^AW. The relative mode treats the field as a two's-complement displacement from the address of the next instruction.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (implied) completes with `kind_o`=0 (none), `value_o`=0 and no register write. The `kind_o` encoding is 0 none, 1 operand, 2 address.
- R2: Mode code 1 (immediate) completes with `kind_o`=1 and `value_o` equal to the address field.
- R3: Mode code 2 (register) completes with `kind_o`=1 and `value_o` equal to the content of the register picked by the RSEL_W-bit selector, which reaches any of 2^RSEL_W registers.
- R4: Mode code 3 (register indirect) completes with `kind_o`=2 and `value_o` equal to the selected register's content.
- R5: Mode code 4 (post-increment) returns the register's old content as the address (`kind_o`=2). In the same cycle as done it writes old+1, modulo 2^AW, back to that register.
- R6: Mode code 5 (post-decrement) returns the old content as the address. In the done cycle it writes old-1, modulo 2^AW, back to that register.
- R7: Mode code 7 (memory indirect) raises `mem_req_o` with `mem_addr_o` equal to the field. It holds both until `mem_valid_i` is seen, then signals done on the next cycle with `kind_o`=2 and `value_o` equal to the word read. A start that arrives while the unit waits is ignored.
- R8: Mode code 6 (direct) completes with `kind_o`=2 and `value_o` equal to the field.
- R9: Mode code 8 (relative) gives the address pc+1+field modulo 2^AW, with the field read as a two's-complement number.
- R10: Mode codes 9 (indexed) and 10 (base) both give the selected register plus the field, modulo 2^AW.
- R11: Mode codes 11 to 15 complete with `illegal_o`=1, `kind_o`=0 and no register write.
- R12: Every mode other than code 7 raises `done_o` for exactly one cycle, on the clock edge after the start. Out of reset, `done_o`, `mem_req_o` and `rf_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a computation with the inputs below |
| mode_i | input | 4 | Addressing mode code |
| rsel_i | input | RSEL_W | Register selector |
| field_i | input | AW | Address, operand or displacement field |
| pc_i | input | AW | Address of the current instruction |
| rf_raddr_o | output | RSEL_W | Register file read address |
| rf_rdata_i | input | AW | Register file read data (combinational) |
| rf_we_o | output | 1 | Register write-back enable |
| rf_waddr_o | output | RSEL_W | Register write-back address |
| rf_wdata_o | output | AW | Register write-back data |
| mem_req_o | output | 1 | Pointer read request |
| mem_addr_o | output | AW | Pointer read address |
| mem_valid_i | input | 1 | Pointer read data valid |
| mem_rdata_i | input | AW | Pointer read data |
| done_o | output | 1 | Result valid strobe |
| kind_o | output | 2 | Result kind: 0 none, 1 operand, 2 address |
| value_o | output | AW | Operand or effective address |
| illegal_o | output | 1 | Mode code not defined |

## Verification
The bench builds the unit with AW=10 and RSEL_W=2. A 10-bit address brings the relative-mode example (825 with 24 giving 850) and the wrap past 1023 within reach. Four registers let every selector value be used, and the post-increment and post-decrement modes can be driven through 0x3FF→0 and 0→0x3FF. The model's expected register contents are then compared against later register-mode reads. A memory latency of several cycles leaves room to issue a stray start during the indirect wait.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam logic [3:0] M_IMPL = 4'd0;
  localparam logic [3:0] M_IMM  = 4'd1;
  localparam logic [3:0] M_REG  = 4'd2;
  localparam logic [3:0] M_RIND = 4'd3;
  localparam logic [3:0] M_AINC = 4'd4;
  localparam logic [3:0] M_ADEC = 4'd5;
  localparam logic [3:0] M_DIR  = 4'd6;
  localparam logic [3:0] M_IND  = 4'd7;
  localparam logic [3:0] M_REL  = 4'd8;
  localparam logic [3:0] M_IDX  = 4'd9;
  localparam logic [3:0] M_BASE = 4'd10;

  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_OPND = 2'd1;
  localparam logic [1:0] K_ADDR = 2'd2;

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  typedef struct packed {
    logic [1:0] kind;
    logic       pass_field;
    logic       use_reg;
    logic       use_pc;
    logic       add_field;
    logic       wb;
    logic       wb_dec;
    logic       mem;
    logic       illegal;
  } dec_t;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [3:0] mode_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (mode_i)
      M_IMPL: dec_o.kind = K_NONE;
      M_IMM:  begin dec_o.kind = K_OPND; dec_o.pass_field = 1'b1; end
      M_REG:  begin dec_o.kind = K_OPND; dec_o.use_reg = 1'b1; end
      M_RIND: begin dec_o.kind = K_ADDR; dec_o.use_reg = 1'b1; end
      M_AINC: begin dec_o.kind = K_ADDR; dec_o.use_reg = 1'b1; dec_o.wb = 1'b1; end
      M_ADEC: begin
        dec_o.kind = K_ADDR; dec_o.use_reg = 1'b1; dec_o.wb = 1'b1; dec_o.wb_dec = 1'b1;
      end
      M_DIR:  begin dec_o.kind = K_ADDR; dec_o.pass_field = 1'b1; end
      M_IND:  begin dec_o.kind = K_ADDR; dec_o.mem = 1'b1; end
      M_REL:  begin dec_o.kind = K_ADDR; dec_o.use_pc = 1'b1; dec_o.add_field = 1'b1; end
      M_IDX, M_BASE: begin
        dec_o.kind = K_ADDR; dec_o.use_reg = 1'b1; dec_o.add_field = 1'b1;
      end
      default: dec_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  dec_t          dec_i,
  input  logic [AW-1:0] reg_i,
  input  logic [AW-1:0] field_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] value_o,
  output logic [AW-1:0] wb_data_o
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] base;

  always_comb begin
    if (dec_i.use_pc)       base = pc_i + ONE;  // next-instruction address
    else if (dec_i.use_reg) base = reg_i;
    else                    base = '0;
    if (dec_i.pass_field)     value_o = field_i;
    else if (dec_i.add_field) value_o = base + field_i;  // wraps mod 2^AW
    else                      value_o = base;
    wb_data_o = dec_i.wb_dec ? reg_i - ONE : reg_i + ONE;
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned RSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RSEL_W-1:0] rsel_i,
  input  logic [AW-1:0]     field_i,
  input  dec_t              dec_i,
  input  logic [AW-1:0]     value_i,
  input  logic [AW-1:0]     wb_data_i,
  input  logic              mem_valid_i,
  input  logic [AW-1:0]     mem_rdata_i,
  output logic              done_o,
  output logic [1:0]        kind_o,
  output logic [AW-1:0]     value_o,
  output logic              illegal_o,
  output logic              rf_we_o,
  output logic [RSEL_W-1:0] rf_waddr_o,
  output logic [AW-1:0]     rf_wdata_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o
);
  st_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      done_o     <= 1'b0;
      kind_o     <= K_NONE;
      value_o    <= '0;
      illegal_o  <= 1'b0;
      rf_we_o    <= 1'b0;
      rf_waddr_o <= '0;
      rf_wdata_o <= '0;
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
    end else begin
      done_o  <= 1'b0;
      rf_we_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (dec_i.mem) begin
              state_q    <= ST_WAIT;
              mem_req_o  <= 1'b1;
              mem_addr_o <= field_i;
            end else begin
              done_o     <= 1'b1;
              kind_o     <= dec_i.kind;
              value_o    <= value_i;
              illegal_o  <= dec_i.illegal;
              rf_we_o    <= dec_i.wb;
              rf_waddr_o <= rsel_i;
              rf_wdata_o <= wb_data_i;
            end
          end
        end
        ST_WAIT: begin
          // start_i ignored here
          if (mem_valid_i) begin
            state_q   <= ST_IDLE;
            mem_req_o <= 1'b0;
            done_o    <= 1'b1;
            kind_o    <= K_ADDR;
            value_o   <= mem_rdata_i;
            illegal_o <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned RSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        mode_i,
  input  logic [RSEL_W-1:0] rsel_i,
  input  logic [AW-1:0]     field_i,
  input  logic [AW-1:0]     pc_i,
  output logic [RSEL_W-1:0] rf_raddr_o,
  input  logic [AW-1:0]     rf_rdata_i,
  output logic              rf_we_o,
  output logic [RSEL_W-1:0] rf_waddr_o,
  output logic [AW-1:0]     rf_wdata_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [AW-1:0]     mem_rdata_i,
  output logic              done_o,
  output logic [1:0]        kind_o,
  output logic [AW-1:0]     value_o,
  output logic              illegal_o
);
  dec_t          dec;
  logic [AW-1:0] calc_value;
  logic [AW-1:0] calc_wb;

  assign rf_raddr_o = rsel_i;

  ea_decode i_decode (.mode_i(mode_i), .dec_o(dec));

  ea_calc #(.AW(AW)) i_calc (
    .dec_i(dec), .reg_i(rf_rdata_i), .field_i(field_i), .pc_i(pc_i),
    .value_o(calc_value), .wb_data_o(calc_wb)
  );

  ea_ctrl #(.AW(AW), .RSEL_W(RSEL_W)) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rsel_i(rsel_i),
    .field_i(field_i), .dec_i(dec), .value_i(calc_value), .wb_data_i(calc_wb),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .kind_o(kind_o), .value_o(value_o), .illegal_o(illegal_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o)
  );
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
  import ea_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic          rf_we_o,
  input logic [AW-1:0] rf_wdata_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_valid_i,
  input logic [AW-1:0] mem_rdata_i,
  input logic          done_o,
  input logic [1:0]    kind_o,
  input logic [AW-1:0] value_o,
  input logic          illegal_o
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  AST_WB_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> done_o && kind_o == K_ADDR); // R5
  AST_WB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_wdata_o == value_o + ONE || rf_wdata_o == value_o - ONE)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)); // R7
  AST_REQ_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o); // R7
  AST_PTR_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i |=> done_o && kind_o == K_ADDR && value_o == $past(mem_rdata_i)); // R7
  AST_ILLEGAL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && illegal_o |-> kind_o == K_NONE && !rf_we_o); // R11
  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !mem_req_o && mode_i != M_IND |=> done_o && !mem_req_o); // R12
endmodule

bind ea_unit ea_unit_chk #(.AW(AW)) i_ea_unit_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
  .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o), .mem_req_o(mem_req_o),
  .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
  .done_o(done_o), .kind_o(kind_o), .value_o(value_o), .illegal_o(illegal_o)
);

// File: tb/test_ea_unit.sv
`timescale 1ns/1ps
module test_ea_unit;
  localparam int AW = 10;
  localparam int RW = 2;
  localparam int MASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [RW-1:0] rsel = '0;
  logic [AW-1:0] field = '0;
  logic [AW-1:0] pc = '0;
  logic [RW-1:0] rf_raddr;
  logic [AW-1:0] rf_rdata;
  logic rf_we;
  logic [RW-1:0] rf_waddr;
  logic [AW-1:0] rf_wdata;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic mem_valid = 1'b0;
  logic [AW-1:0] mem_rdata = '0;
  logic done;
  logic [1:0] kind;
  logic [AW-1:0] value;
  logic illegal;

  int n_tests = 0;
  int n_fail = 0;
  logic [AW-1:0] rf [4];
  int ref_r [4];

  always #5 clk = ~clk;

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rf[0] <= 10'h005; rf[1] <= 10'h3FF; rf[2] <= 10'h000; rf[3] <= 10'h100;
    end else if (rf_we) rf[rf_waddr] <= rf_wdata;

  ea_unit #(.AW(AW), .RSEL_W(RW)) i_ea_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .rsel_i(rsel),
    .field_i(field), .pc_i(pc), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid),
    .mem_rdata_i(mem_rdata), .done_o(done), .kind_o(kind), .value_o(value),
    .illegal_o(illegal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference for one non-memory operation
  task automatic do_op(input int m, input int r, input int f, input int p, input string req);
    int ek, ev, ew, ewd, ei;
    ek = 0; ev = 0; ew = 0; ewd = 0; ei = 0;
    case (m)
      0: begin ek = 0; ev = 0; end
      1: begin ek = 1; ev = f; end
      2: begin ek = 1; ev = ref_r[r]; end
      3: begin ek = 2; ev = ref_r[r]; end
      4: begin ek = 2; ev = ref_r[r]; ew = 1; ewd = (ref_r[r] + 1) & MASK; end
      5: begin ek = 2; ev = ref_r[r]; ew = 1; ewd = (ref_r[r] - 1) & MASK; end
      6: begin ek = 2; ev = f; end
      8: begin ek = 2; ev = (p + 1 + f) & MASK; end
      9, 10: begin ek = 2; ev = (ref_r[r] + f) & MASK; end
      default: begin ei = 1; ek = 0; end
    endcase
    @(negedge clk);
    start = 1'b1; mode = 4'(m); rsel = RW'(r); field = AW'(f); pc = AW'(p);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, {req, " done"}, int'(done), 1);
    check(int'(kind) == ek, {req, " kind"}, int'(kind), ek);
    if (ei == 0 && ek != 0) check(int'(value) == ev, {req, " value"}, int'(value), ev);
    check(int'(illegal) == ei, {req, " illegal"}, int'(illegal), ei);
    check(int'(rf_we) == ew, {req, " write enable"}, int'(rf_we), ew);
    if (ew != 0) begin
      check(int'(rf_waddr) == r, {req, " write addr"}, int'(rf_waddr), r);
      check(int'(rf_wdata) == ewd, {req, " write data"}, int'(rf_wdata), ewd);
      ref_r[r] = ewd;
    end
    @(negedge clk);
    check(done == 1'b0, "R12 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    ref_r[0] = 'h005; ref_r[1] = 'h3FF; ref_r[2] = 'h000; ref_r[3] = 'h100;
    repeat (3) @(negedge clk);
    check(done == 0 && mem_req == 0 && rf_we == 0, "R12 reset state",
          int'({done, mem_req, rf_we}), 0);
    rst_n = 1'b1;
    do_op(0, 1, 'h12, 0, "R1 implied");
    do_op(1, 0, 'h2C7, 0, "R2 immediate");
    do_op(2, 3, 0, 0, "R3 register r3");
    do_op(2, 0, 0, 0, "R3 register r0");
    do_op(3, 3, 'h55, 0, "R4 register indirect");
    do_op(4, 1, 0, 0, "R5 post-increment wrap");
    do_op(2, 1, 0, 0, "R5 reg after increment");
    do_op(5, 2, 0, 0, "R6 post-decrement wrap");
    do_op(2, 2, 0, 0, "R6 reg after decrement");
    do_op(6, 0, 'h1A3, 0, "R8 direct");
    do_op(8, 0, 24, 825, "R9 relative 825+24");
    do_op(8, 0, 0, 1023, "R9 relative wrap");
    do_op(8, 0, 'h3FB, 100, "R9 relative negative");
    do_op(9, 3, 'h23, 0, "R10 indexed");
    do_op(10, 0, 'h3FE, 0, "R10 base wrap");
    do_op(12, 1, 0, 0, "R11 illegal 12");
    do_op(15, 3, 0, 0, "R11 illegal 15");
    // R7 memory indirect, latency 3, stray start during wait
    @(negedge clk);
    start = 1'b1; mode = 4'd7; field = 'h055;
    @(negedge clk);
    start = 1'b0;
    check(mem_req == 1'b1, "R7 request", int'(mem_req), 1);
    check(int'(mem_addr) == 'h055, "R7 request addr", int'(mem_addr), 'h055);
    check(done == 1'b0, "R7 no early done", int'(done), 0);
    start = 1'b1; mode = 4'd6; field = 'h111;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && mem_req == 1'b1, "R7 start ignored while waiting",
          int'({done, mem_req}), 1);
    @(negedge clk);
    check(int'(mem_addr) == 'h055, "R7 addr held", int'(mem_addr), 'h055);
    mem_valid = 1'b1; mem_rdata = 'h2AA;
    @(negedge clk);
    mem_valid = 1'b0;
    check(done == 1'b1, "R7 done after valid", int'(done), 1);
    check(int'(value) == 'h2AA && kind == 2'd2, "R7 pointer result", int'(value), 'h2AA);
    check(mem_req == 1'b0, "R7 request dropped", int'(mem_req), 0);
    @(negedge clk);
    check(done == 1'b0, "R7 no done from stray start", int'(done), 0);
    do_op(3, 1, 0, 0, "R4 after indirect");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule